// File: doc/BRIEF.md
# Word and Byte Memory Port Adapter

This block puts one byte-organised RAM behind two access paths. An instruction fetch path takes a byte address and returns the single byte held there. A data path takes a word address, turns it into a byte address by multiplying by four, and reads or writes the four consecutive bytes starting there in little-endian order. A third port writes one byte per cycle directly into the array so that a program image can be placed before execution starts.

Both request paths use valid/ready. A request is taken on a clock edge where valid and ready are both high. Ready is low while reset is asserted and high at all other times, so a requester never has to wait once reset has been released. Responses come back exactly one cycle after acceptance with a valid strobe and no back-pressure: the consumer must take the response in that cycle. Every byte that has not been written since the last reset reads as zero. Any access whose last byte lies beyond the final byte of the array is refused and flagged as an error. Such an access returns zero data and changes no memory.

Top module: `wbm_port_adapter`

## Requirements
- R1: A data request with word address W addresses byte W*4 as its base byte.
- R2: A data write of word D stores D[7:0] at base, D[15:8] at base+1, D[23:16] at base+2 and D[31:24] at base+3.
- R3: A data read returns the byte at base+3 in bits 31:24, base+2 in 23:16, base+1 in 15:8 and base in 7:0, so a read after a write returns the written word.
- R4: A fetch request with byte address A returns the byte stored at A, with no scaling of the address.
- R5: Every byte not written since the end of the last reset reads as 0x00 on both paths.
- R6: A fetch with A greater than BYTES-1 responds with the error flag set to 1 and data 0x00. An in-range fetch responds with the error flag set to 0.
- R7: A data request with W*4+3 greater than BYTES-1 responds with the error flag set to 1 and read data 0. For a write, no byte changes, including the in-range bytes of a partial word.
- R8: Each accepted request produces its response valid for exactly one cycle, one cycle after acceptance. A data write also responds, with read data 0.
- R9: Both request ready outputs are 0 while reset is high and 1 otherwise.
- R10: The load port writes one byte per cycle at byte address A when A is at most BYTES-1. When the load port and a data write hit the same byte in the same cycle, the loaded byte is kept.
- R11: A read of a byte in the same cycle that a write to it is accepted returns the previous content of that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; forgets every written byte |
| ld_en | input | 1 | Load port byte write strobe |
| ld_addr | input | FA_W | Load port byte address |
| ld_data | input | 8 | Load port byte value |
| fet_req_valid | input | 1 | Fetch request valid |
| fet_req_ready | output | 1 | Fetch request ready |
| fet_req_addr | input | FA_W | Fetch byte address |
| fet_rsp_valid | output | 1 | Fetch response valid |
| fet_rsp_byte | output | 8 | Fetched byte |
| fet_rsp_err | output | 1 | Fetch address beyond last byte |
| dat_req_valid | input | 1 | Data request valid |
| dat_req_ready | output | 1 | Data request ready |
| dat_req_we | input | 1 | 1 selects a write, 0 selects a read |
| dat_req_waddr | input | WA_W | Data word address |
| dat_req_wdata | input | 32 | Word to write |
| dat_rsp_valid | output | 1 | Data response valid |
| dat_rsp_rdata | output | 32 | Word read, zero for writes and errors |
| dat_rsp_err | output | 1 | Word extends beyond last byte |

## Verification
The assertions assume that requesters present a request only while ready is high. They also assume that each request is dropped once it has been accepted, that responses are consumed in the cycle they appear, and that the load port is not used during reset. The stimulus raises each valid for one cycle at a time after reset has been released. It also sweeps addresses on purpose past the final byte, including a word that straddles the end, so that the range checks are exercised within these rules. Same-cycle collisions are produced deliberately: a load and a data write to the same byte, and a fetch of a byte that a data write is changing in that cycle.

// File: rtl/wbm_pkg.sv
package wbm_pkg;
  typedef logic [7:0]  byte_t;
  typedef logic [31:0] word_t;
  localparam int LANES = 4;
endpackage

// File: rtl/wbm_range_chk.sv
// Decides whether an access of SPAN bytes starting at base stays inside
// the array. The sum is formed one bit wider so it cannot wrap.
module wbm_range_chk #(
  parameter int AW   = 18,
  parameter int SPAN = 1,
  parameter int LAST = 61
) (
  input  logic [AW-1:0] base,
  output logic          in_range
);
  localparam int EW = AW + 1;

  logic [EW-1:0] end_byte;

  assign end_byte = {1'b0, base} + EW'(SPAN - 1);
  assign in_range = (end_byte <= EW'(LAST));
endmodule

// File: rtl/wbm_word_lanes.sv
// Splits a word into byte lanes and joins lanes back into a word.
// Lane k is bits 8k+7:8k.
module wbm_word_lanes
  import wbm_pkg::*;
(
  input  word_t                  wr_word,
  output logic [LANES-1:0][7:0]  wr_lanes,
  input  logic [LANES-1:0][7:0]  rd_lanes,
  output word_t                  rd_word
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign wr_lanes[k]       = wr_word[8*k +: 8];
    assign rd_word[8*k +: 8] = rd_lanes[k];
  end
endmodule

// File: rtl/wbm_byte_store.sv
// Byte array with a written flag per byte. The flags are cleared by reset,
// so a byte whose flag is clear reads as zero. Write port 0 has the
// highest priority when ports collide on one byte.
module wbm_byte_store #(
  parameter int BYTES = 62,
  parameter int NWR   = 5,
  parameter int NRD   = 5,
  localparam int IDX_W = $clog2(BYTES)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NWR-1:0]              wr_en,
  input  logic [NWR-1:0][IDX_W-1:0]   wr_idx,
  input  logic [NWR-1:0][7:0]         wr_byte,
  input  logic [NRD-1:0][IDX_W-1:0]   rd_idx,
  output logic [NRD-1:0][7:0]         rd_byte
);
  logic [7:0]       cells [BYTES];
  logic [BYTES-1:0] wflag;

  // Data cells: no reset needed, the flags gate them.
  always_ff @(posedge clk) begin
    for (int b = 0; b < BYTES; b++) begin
      for (int p = NWR - 1; p >= 0; p--) begin
        if (wr_en[p] && wr_idx[p] == IDX_W'(b)) cells[b] <= wr_byte[p];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wflag <= '0;
    end else begin
      for (int b = 0; b < BYTES; b++) begin
        for (int p = 0; p < NWR; p++) begin
          if (wr_en[p] && wr_idx[p] == IDX_W'(b)) wflag[b] <= 1'b1;
        end
      end
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rd_byte[r] = wflag[rd_idx[r]] ? cells[rd_idx[r]] : 8'h00;
  end

  // After any write by port 0 the target byte counts as written (R5).
  p_write_marks_r5: assert property (@(posedge clk) disable iff (rst)
    wr_en[0] |=> wflag[$past(wr_idx[0])]);

  // Port 0 wins over port 1 on the same byte (R10).
  p_load_priority_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_en[0] && wr_en[1] && wr_idx[0] == wr_idx[1])
      |=> cells[$past(wr_idx[0])] == $past(wr_byte[0]));
endmodule

// File: rtl/wbm_port_adapter.sv
// Front end that serves a byte fetch path, a little-endian word data path
// and an image load port from one byte array.
module wbm_port_adapter
  import wbm_pkg::*;
#(
  parameter int BYTES = 62,
  parameter int FA_W  = 16,
  parameter int WA_W  = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ld_en,
  input  logic [FA_W-1:0] ld_addr,
  input  logic [7:0]      ld_data,
  input  logic            fet_req_valid,
  output logic            fet_req_ready,
  input  logic [FA_W-1:0] fet_req_addr,
  output logic            fet_rsp_valid,
  output logic [7:0]      fet_rsp_byte,
  output logic            fet_rsp_err,
  input  logic            dat_req_valid,
  output logic            dat_req_ready,
  input  logic            dat_req_we,
  input  logic [WA_W-1:0] dat_req_waddr,
  input  logic [31:0]     dat_req_wdata,
  output logic            dat_rsp_valid,
  output logic [31:0]     dat_rsp_rdata,
  output logic            dat_rsp_err
);
  localparam int LAST  = BYTES - 1;
  localparam int IDX_W = $clog2(BYTES);
  localparam int DA_W  = WA_W + 2;
  localparam int NPORT = LANES + 1;

  logic            fet_acc, dat_acc;
  logic            fet_ok, dat_ok, ld_ok;
  logic [DA_W-1:0] dat_base;
  logic            dat_wr_go, ld_go;

  logic [NPORT-1:0]            wr_en;
  logic [NPORT-1:0][IDX_W-1:0] wr_idx;
  logic [NPORT-1:0][7:0]       wr_byte;
  logic [NPORT-1:0][IDX_W-1:0] rd_idx;
  logic [NPORT-1:0][7:0]       rd_byte;

  logic [LANES-1:0][7:0] wr_lanes;
  logic [LANES-1:0][7:0] rd_lanes;
  word_t                 rd_word;

  assign fet_req_ready = ~rst;
  assign dat_req_ready = ~rst;
  assign fet_acc       = fet_req_valid & fet_req_ready;
  assign dat_acc       = dat_req_valid & dat_req_ready;
  assign dat_base      = {dat_req_waddr, 2'b00};

  wbm_range_chk #(.AW(FA_W), .SPAN(1), .LAST(LAST)) u_fet_rng (
    .base(fet_req_addr), .in_range(fet_ok));
  wbm_range_chk #(.AW(DA_W), .SPAN(LANES), .LAST(LAST)) u_dat_rng (
    .base(dat_base), .in_range(dat_ok));
  wbm_range_chk #(.AW(FA_W), .SPAN(1), .LAST(LAST)) u_ld_rng (
    .base(ld_addr), .in_range(ld_ok));

  assign ld_go     = ld_en & ld_ok & ~rst;
  assign dat_wr_go = dat_acc & dat_req_we & dat_ok;

  wbm_word_lanes u_lanes (
    .wr_word (dat_req_wdata),
    .wr_lanes(wr_lanes),
    .rd_lanes(rd_lanes),
    .rd_word (rd_word)
  );

  // Port 0: load port (write) and fetch path (read).
  assign wr_en[0]   = ld_go;
  assign wr_idx[0]  = ld_addr[IDX_W-1:0];
  assign wr_byte[0] = ld_data;
  assign rd_idx[0]  = fet_req_addr[IDX_W-1:0];

  // Ports 1..4: one per byte lane of the data word.
  for (genvar k = 0; k < LANES; k++) begin : g_port
    assign wr_en[k+1]   = dat_wr_go;
    assign wr_idx[k+1]  = dat_base[IDX_W-1:0] + IDX_W'(k);
    assign wr_byte[k+1] = wr_lanes[k];
    assign rd_idx[k+1]  = dat_base[IDX_W-1:0] + IDX_W'(k);
    assign rd_lanes[k]  = rd_byte[k+1];
  end

  wbm_byte_store #(.BYTES(BYTES), .NWR(NPORT), .NRD(NPORT)) u_store (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .wr_byte(wr_byte),
    .rd_idx (rd_idx),
    .rd_byte(rd_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fet_rsp_valid <= 1'b0;
      fet_rsp_byte  <= '0;
      fet_rsp_err   <= 1'b0;
      dat_rsp_valid <= 1'b0;
      dat_rsp_rdata <= '0;
      dat_rsp_err   <= 1'b0;
    end else begin
      fet_rsp_valid <= fet_acc;
      fet_rsp_byte  <= (fet_acc && fet_ok) ? rd_byte[0] : 8'h00;
      fet_rsp_err   <= fet_acc & ~fet_ok;
      dat_rsp_valid <= dat_acc;
      dat_rsp_rdata <= (dat_acc && !dat_req_we && dat_ok) ? rd_word : '0;
      dat_rsp_err   <= dat_acc & ~dat_ok;
    end
  end

  p_fet_latency_r8: assert property (@(posedge clk) disable iff (rst)
    (fet_req_valid && fet_req_ready) |=> fet_rsp_valid);

  p_fet_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !(fet_req_valid && fet_req_ready) |=> !fet_rsp_valid);

  p_dat_latency_r8: assert property (@(posedge clk) disable iff (rst)
    (dat_req_valid && dat_req_ready) |=> dat_rsp_valid);

  p_fet_range_r6: assert property (@(posedge clk) disable iff (rst)
    (fet_acc && ({1'b0, fet_req_addr} > (FA_W+1)'(LAST)))
      |=> (fet_rsp_err && fet_rsp_byte == 8'h00));

  p_dat_range_r7: assert property (@(posedge clk) disable iff (rst)
    (dat_acc && (({1'b0, dat_base} + (DA_W+1)'(3)) > (DA_W+1)'(LAST)))
      |=> (dat_rsp_err && dat_rsp_rdata == 32'h0));

  p_write_rsp_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (dat_acc && dat_req_we) |=> dat_rsp_rdata == 32'h0);
endmodule

// File: tb/wbm_port_adapter_tb.sv
module wbm_port_adapter_tb_top;
  localparam int NB   = 62;
  localparam int FA_W = 16;
  localparam int WA_W = 16;

  logic            clk = 1'b0;
  logic            rst;
  logic            ld_en;
  logic [FA_W-1:0] ld_addr;
  logic [7:0]      ld_data;
  logic            fet_req_valid, fet_req_ready;
  logic [FA_W-1:0] fet_req_addr;
  logic            fet_rsp_valid, fet_rsp_err;
  logic [7:0]      fet_rsp_byte;
  logic            dat_req_valid, dat_req_ready, dat_req_we;
  logic [WA_W-1:0] dat_req_waddr;
  logic [31:0]     dat_req_wdata, dat_rsp_rdata;
  logic            dat_rsp_valid, dat_rsp_err;

  int   checks = 0;
  int   errors = 0;
  bit   done   = 0;
  logic [7:0] refm [NB];

  always #4 clk = ~clk;

  wbm_port_adapter #(.BYTES(NB), .FA_W(FA_W), .WA_W(WA_W)) dut_i (
    .clk(clk), .rst(rst),
    .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .fet_req_valid(fet_req_valid), .fet_req_ready(fet_req_ready),
    .fet_req_addr(fet_req_addr), .fet_rsp_valid(fet_rsp_valid),
    .fet_rsp_byte(fet_rsp_byte), .fet_rsp_err(fet_rsp_err),
    .dat_req_valid(dat_req_valid), .dat_req_ready(dat_req_ready),
    .dat_req_we(dat_req_we), .dat_req_waddr(dat_req_waddr),
    .dat_req_wdata(dat_req_wdata), .dat_rsp_valid(dat_rsp_valid),
    .dat_rsp_rdata(dat_rsp_rdata), .dat_rsp_err(dat_rsp_err)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %h exp %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input int w);
    int b = w * 4;
    if (b + 3 > NB - 1) return 32'h0;
    return {refm[b+3], refm[b+2], refm[b+1], refm[b]};
  endfunction

  task automatic clear_ref();
    for (int i = 0; i < NB; i++) refm[i] = 8'h00;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(fet_req_ready == 1'b0 && dat_req_ready == 1'b0, "R9 ready in reset",
        {30'd0, fet_req_ready, dat_req_ready}, 32'h0);
    chk(fet_rsp_valid == 1'b0 && dat_rsp_valid == 1'b0, "R8 no rsp in reset",
        {30'd0, fet_rsp_valid, dat_rsp_valid}, 32'h0);
    rst = 1'b0;
    clear_ref();
    @(negedge clk);
    chk(fet_req_ready && dat_req_ready, "R9 ready after reset",
        {30'd0, fet_req_ready, dat_req_ready}, 32'h3);
  endtask

  task automatic fetch_chk(input int a, input string req);
    logic [7:0] e;
    bit         ee;
    e  = (a <= NB - 1) ? refm[a] : 8'h00;
    ee = (a > NB - 1);
    fet_req_valid = 1'b1;
    fet_req_addr  = FA_W'(a);
    @(negedge clk);
    fet_req_valid = 1'b0;
    chk(fet_rsp_valid == 1'b1, "R8 fetch rsp valid", {31'd0, fet_rsp_valid}, 32'h1);
    chk(fet_rsp_byte == e, req, {24'd0, fet_rsp_byte}, {24'd0, e});
    chk(fet_rsp_err == ee, "R6 fetch err flag", {31'd0, fet_rsp_err}, {31'd0, ee});
  endtask

  task automatic fetch_sweep(input string req);
    for (int a = 0; a < NB + 8; a++) fetch_chk(a, req);
    @(negedge clk);
    chk(fet_rsp_valid == 1'b0, "R8 single-cycle fetch rsp", {31'd0, fet_rsp_valid}, 32'h0);
  endtask

  task automatic dread_chk(input int w, input string req);
    logic [31:0] e;
    bit          ee;
    e  = exp_word(w);
    ee = (w * 4 + 3 > NB - 1);
    dat_req_valid = 1'b1;
    dat_req_we    = 1'b0;
    dat_req_waddr = WA_W'(w);
    @(negedge clk);
    dat_req_valid = 1'b0;
    chk(dat_rsp_valid == 1'b1, "R8 data rsp valid", {31'd0, dat_rsp_valid}, 32'h1);
    chk(dat_rsp_rdata == e, req, dat_rsp_rdata, e);
    chk(dat_rsp_err == ee, "R7 data err flag", {31'd0, dat_rsp_err}, {31'd0, ee});
  endtask

  task automatic dread_sweep(input string req);
    for (int w = 0; w < NB / 4 + 3; w++) dread_chk(w, req);
    @(negedge clk);
    chk(dat_rsp_valid == 1'b0, "R8 single-cycle data rsp", {31'd0, dat_rsp_valid}, 32'h0);
  endtask

  task automatic ref_word(input int w, input logic [31:0] d);
    int b = w * 4;
    if (b + 3 <= NB - 1)
      for (int k = 0; k < 4; k++) refm[b+k] = d[8*k +: 8];
  endtask

  task automatic dwrite(input int w, input logic [31:0] d);
    bit ee = (w * 4 + 3 > NB - 1);
    dat_req_valid = 1'b1;
    dat_req_we    = 1'b1;
    dat_req_waddr = WA_W'(w);
    dat_req_wdata = d;
    @(negedge clk);
    dat_req_valid = 1'b0;
    dat_req_we    = 1'b0;
    chk(dat_rsp_valid == 1'b1, "R8 write rsp valid", {31'd0, dat_rsp_valid}, 32'h1);
    chk(dat_rsp_rdata == 32'h0, "R8 write rsp data zero", dat_rsp_rdata, 32'h0);
    chk(dat_rsp_err == ee, "R7 write err flag", {31'd0, dat_rsp_err}, {31'd0, ee});
    ref_word(w, d);
  endtask

  task automatic load(input int a, input logic [7:0] d);
    ld_en   = 1'b1;
    ld_addr = FA_W'(a);
    ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
    if (a <= NB - 1) refm[a] = d;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; ld_en = 0; ld_addr = '0; ld_data = '0;
    fet_req_valid = 0; fet_req_addr = '0;
    dat_req_valid = 0; dat_req_we = 0; dat_req_waddr = '0; dat_req_wdata = '0;
    clear_ref();
    do_reset();

    // Empty memory: zeros, range errors beyond the end.
    fetch_sweep("R5 fetch unwritten zero");
    dread_sweep("R5 word unwritten zero");

    // Load an arithmetic image byte by byte, plus one discarded load.
    for (int i = 0; i < NB; i++) load(i, 8'((i * 37 + 11) & 255));
    load(NB + 8, 8'hFF);
    fetch_sweep("R4 R10 fetch loaded byte");
    dread_sweep("R1 R3 word assembled from bytes");

    // Word writes over the whole range; the last word straddles the end (R7).
    for (int w = 0; w < NB / 4 + 1; w++) dwrite(w, 32'h9E3779B9 * (w + 1));
    fetch_sweep("R2 R7 lane placement");
    dread_sweep("R3 word round trip");

    // Load and data write on the same byte in one cycle (R10).
    ld_en = 1'b1; ld_addr = FA_W'(8); ld_data = 8'h11;
    dat_req_valid = 1'b1; dat_req_we = 1'b1;
    dat_req_waddr = WA_W'(2); dat_req_wdata = 32'hDEADBEEF;
    @(negedge clk);
    ld_en = 1'b0; dat_req_valid = 1'b0; dat_req_we = 1'b0;
    ref_word(2, 32'hDEADBEEF);
    refm[8] = 8'h11;
    for (int a = 8; a < 12; a++) fetch_chk(a, "R10 load priority");

    // Fetch of a byte while a data write changes it (R11).
    fet_req_valid = 1'b1; fet_req_addr = FA_W'(13);
    dat_req_valid = 1'b1; dat_req_we = 1'b1;
    dat_req_waddr = WA_W'(3); dat_req_wdata = 32'h01234567;
    @(negedge clk);
    fet_req_valid = 1'b0; dat_req_valid = 1'b0; dat_req_we = 1'b0;
    chk(fet_rsp_byte == refm[13], "R11 read sees old byte",
        {24'd0, fet_rsp_byte}, {24'd0, refm[13]});
    ref_word(3, 32'h01234567);
    fetch_chk(13, "R11 new byte after write");

    // Reset forgets all contents (R5).
    do_reset();
    fetch_sweep("R5 fetch zero after reset");
    dread_sweep("R5 word zero after reset");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule